// File: doc/BRIEF.md
# Voltage channel command formatter

This block holds the settings of one channel of a voltage controller and turns a power-state request into a three-field write frame for an external power-management chip over I2C. The fields are a 7-bit slave address, an 8-bit register address and a data byte. A downstream arbiter and I2C bit engine take the frame over a valid/ready handshake.

Each field comes either from the channel's own setting or from a shared master channel's setting. A separate enable bit makes that choice for each field. A channel built as the master ignores those enables and always uses its own settings. Software programs three word registers through a simple write port. A request carries a 2-bit state code and a selector that picks the voltage register or the command register as the target. The request is captured together with the values it selects, so register writes made while a frame is waiting only affect later requests. On channels where the OFF state is reserved, an OFF request is refused with a one-cycle error pulse.

Top module: `vchan_fmt`

## Requirements
- R1: After reset `frm_valid` and `req_err` are 0, `req_ready` is 1, and every setting and enable is 0. An unconfigured non-master channel therefore sends the master slave address, the master voltage-register address and the master command values.
- R2: A request is taken in any cycle where `req_valid` and `req_ready` are both 1. Unless it is refused, `frm_valid` rises one cycle later. `req_ready` is low while a frame is pending.
- R3: While `frm_valid` is 1 and `frm_ready` is 0, the frame fields stay stable. In the cycle after a handshake, `frm_valid` is 0.
- R4: The settings are written through `wr_idx`. Index 0 holds the enables: bit0 selects the own slave address, bit1 the own voltage-register address, bit2 the own command-register address, bit3 makes the command register alias to the voltage register, and bit4 selects the own command values. Index 1 holds the addresses: slave address in [6:0], voltage-register address in [15:8], command-register address in [23:16]. Index 2 holds the command values. Index 3 and all unlisted bits are ignored.
- R5: `frm_slave` is the own slave address when enable bit0 is set, and the master's `mst_slave` otherwise.
- R6: With `req_cmd`=0, `frm_reg` is the voltage-register address: the own value if bit1 is set, `mst_vreg` otherwise. With `req_cmd`=1 it is the command-register address: the own value if bit2 is set, `mst_creg` otherwise. When bit3 is set, a `req_cmd`=1 request uses the voltage-register address instead.
- R7: `frm_data` is the byte of the state in the selected command values. ON (code 0) is bits [31:24], ON-low-power (code 1) is [23:16], RETENTION (code 2) is [15:8] and OFF (code 3) is [7:0]. The selected values are the own ones if bit4 is set and `mst_cmdval` otherwise.
- R8: With OFF_RESERVED=1, a taken OFF request makes no frame. Instead `req_err` is 1 for exactly the next cycle, and `req_ready` stays 1.
- R9: With IS_MASTER=1 every field uses the channel's own setting whatever the enables in bits 0, 1, 2 and 4. The alias in bit3 still applies.
- R10: Writes made while a frame is pending do not change that frame. They take effect from the next request on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 2 | Register index |
| wr_data | input | 32 | Register write data |
| mst_slave | input | 7 | Master channel slave address |
| mst_vreg | input | 8 | Master channel voltage-register address |
| mst_creg | input | 8 | Master channel command-register address |
| mst_cmdval | input | 32 | Master channel command values |
| req_valid | input | 1 | State request strobe |
| req_state | input | 2 | State code: 0 ON, 1 ON-low-power, 2 RETENTION, 3 OFF |
| req_cmd | input | 1 | 0 targets the voltage register, 1 targets the command register |
| req_ready | output | 1 | Channel can take a request |
| req_err | output | 1 | One-cycle pulse for a refused OFF request |
| frm_valid | output | 1 | Frame pending |
| frm_ready | input | 1 | Arbiter takes the frame |
| frm_slave | output | 7 | Frame slave address |
| frm_reg | output | 8 | Frame register address |
| frm_data | output | 8 | Frame data byte |

## Verification
The assertions assume that `frm_ready` alone decides how long a frame waits, and that a request counts only when `req_ready` is high. The bench raises `req_valid` for a single cycle and only while the channel is idle. The master inputs are changed only between requests, because the channel captures them at acceptance. Random settings, master values, state codes and stall lengths are mixed with directed cases for the reset state, the refused OFF request, ignored writes and writes made while a frame is pending.

// File: rtl/vchan_fmt.sv
module vchan_fmt #(
  parameter bit IS_MASTER    = 1'b0,
  parameter bit OFF_RESERVED = 1'b0,
  parameter int SA_W         = 7,
  parameter int RA_W         = 8,
  parameter int DW           = 8,
  parameter int NSTATE       = 4,
  parameter int BUS_W        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           wr_idx,
  input  logic [BUS_W-1:0]     wr_data,
  input  logic [SA_W-1:0]      mst_slave,
  input  logic [RA_W-1:0]      mst_vreg,
  input  logic [RA_W-1:0]      mst_creg,
  input  logic [NSTATE*DW-1:0] mst_cmdval,
  input  logic                 req_valid,
  input  logic [$clog2(NSTATE)-1:0] req_state,
  input  logic                 req_cmd,
  output logic                 req_ready,
  output logic                 req_err,
  output logic                 frm_valid,
  input  logic                 frm_ready,
  output logic [SA_W-1:0]      frm_slave,
  output logic [RA_W-1:0]      frm_reg,
  output logic [DW-1:0]        frm_data
);
  localparam int SW     = $clog2(NSTATE);
  localparam int VR_LSB = 8;
  localparam int CR_LSB = VR_LSB + RA_W;
  localparam int VW     = NSTATE * DW;
  localparam int E_SA   = 0;
  localparam int E_VR   = 1;
  localparam int E_CR   = 2;
  localparam int E_ALI  = 3;
  localparam int E_CMD  = 4;

  logic [4:0]      cfg_q;
  logic [SA_W-1:0] sa_q;
  logic [RA_W-1:0] vr_q, cr_q;
  logic [VW-1:0]   val_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      sa_q  <= '0;
      vr_q  <= '0;
      cr_q  <= '0;
      val_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        2'd0: cfg_q <= wr_data[4:0];
        2'd1: begin
          sa_q <= wr_data[SA_W-1:0];
          vr_q <= wr_data[VR_LSB +: RA_W];
          cr_q <= wr_data[CR_LSB +: RA_W];
        end
        2'd2: val_q <= wr_data[VW-1:0];
        default: ;
      endcase
    end
  end

  logic unused_wr;
  assign unused_wr = ^wr_data;

  logic            own_sa, own_vr, own_cr, own_val;
  logic [SA_W-1:0] pick_sa;
  logic [RA_W-1:0] pick_vr, pick_cr, pick_reg;
  logic [VW-1:0]   pick_val;
  logic [DW-1:0]   pick_data;
  logic            take, refuse;

  assign own_sa    = IS_MASTER | cfg_q[E_SA];
  assign own_vr    = IS_MASTER | cfg_q[E_VR];
  assign own_cr    = IS_MASTER | cfg_q[E_CR];
  assign own_val   = IS_MASTER | cfg_q[E_CMD];
  assign pick_sa   = own_sa  ? sa_q  : mst_slave;
  assign pick_vr   = own_vr  ? vr_q  : mst_vreg;
  assign pick_cr   = own_cr  ? cr_q  : mst_creg;
  assign pick_val  = own_val ? val_q : mst_cmdval;
  assign pick_reg  = (req_cmd && !cfg_q[E_ALI]) ? pick_cr : pick_vr;
  assign pick_data = pick_val[(NSTATE-1-req_state)*DW +: DW];

  assign req_ready = !frm_valid;
  assign take      = req_valid && req_ready;
  assign refuse    = OFF_RESERVED && (req_state == SW'(NSTATE-1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      req_err   <= 1'b0;
      frm_slave <= '0;
      frm_reg   <= '0;
      frm_data  <= '0;
    end else begin
      req_err <= take && refuse;
      if (frm_valid && frm_ready) begin
        frm_valid <= 1'b0;
      end else if (take && !refuse) begin
        frm_valid <= 1'b1;
        frm_slave <= pick_sa;
        frm_reg   <= pick_reg;
        frm_data  <= pick_data;
      end
    end
  end
endmodule

// File: rtl/vchan_fmt_chk.sv
module vchan_fmt_chk #(
  parameter bit OFF_RESERVED = 1'b0,
  parameter int SA_W   = 7,
  parameter int RA_W   = 8,
  parameter int DW     = 8,
  parameter int NSTATE = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [$clog2(NSTATE)-1:0] req_state,
  input logic                      req_err,
  input logic                      frm_valid,
  input logic                      frm_ready,
  input logic [SA_W-1:0]           frm_slave,
  input logic [RA_W-1:0]           frm_reg,
  input logic [DW-1:0]             frm_data
);
  localparam int SW = $clog2(NSTATE);
  logic is_off;
  assign is_off = OFF_RESERVED && (req_state == SW'(NSTATE-1));

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !frm_ready |=> frm_valid && $stable({frm_slave, frm_reg, frm_data})); // R3
  AST_FRAME_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready |=> !frm_valid); // R3
  AST_ACCEPT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !is_off |=> frm_valid); // R2
  AST_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && is_off |=> req_err && !frm_valid); // R8
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $past(req_valid && req_ready)); // R8
endmodule

bind vchan_fmt vchan_fmt_chk #(
  .OFF_RESERVED(OFF_RESERVED), .SA_W(SA_W), .RA_W(RA_W), .DW(DW), .NSTATE(NSTATE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_state(req_state), .req_err(req_err), .frm_valid(frm_valid),
  .frm_ready(frm_ready), .frm_slave(frm_slave), .frm_reg(frm_reg), .frm_data(frm_data)
);

// File: tb/tb_vchan_fmt.sv
module tb_vchan_fmt;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [1:0] wr_idx = 0;
  logic [31:0] wr_data = 0;
  logic [6:0] mst_slave = 0;
  logic [7:0] mst_vreg = 0, mst_creg = 0;
  logic [31:0] mst_cmdval = 0;
  logic [1:0] req_state = 0;
  logic req_cmd = 0;
  logic rv [2];
  logic fr [2];
  logic rr [2], re [2], fv [2];
  logic [6:0] fs [2];
  logic [7:0] fg [2], fd [2];

  int checks = 0, errors = 0;
  logic [4:0] s_cfg = 0;
  logic [6:0] s_sa = 0;
  logic [7:0] s_vr = 0, s_cr = 0;
  logic [31:0] s_val = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vchan_fmt #(.IS_MASTER(1'b0), .OFF_RESERVED(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mst_slave(mst_slave), .mst_vreg(mst_vreg), .mst_creg(mst_creg), .mst_cmdval(mst_cmdval),
    .req_valid(rv[0]), .req_state(req_state), .req_cmd(req_cmd), .req_ready(rr[0]),
    .req_err(re[0]), .frm_valid(fv[0]), .frm_ready(fr[0]), .frm_slave(fs[0]),
    .frm_reg(fg[0]), .frm_data(fd[0]));

  vchan_fmt #(.IS_MASTER(1'b1), .OFF_RESERVED(1'b1)) dut_m (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mst_slave(mst_slave), .mst_vreg(mst_vreg), .mst_creg(mst_creg), .mst_cmdval(mst_cmdval),
    .req_valid(rv[1]), .req_state(req_state), .req_cmd(req_cmd), .req_ready(rr[1]),
    .req_err(re[1]), .frm_valid(fv[1]), .frm_ready(fr[1]), .frm_slave(fs[1]),
    .frm_reg(fg[1]), .frm_data(fd[1]));

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  function automatic logic [22:0] model(input bit mst, input logic [1:0] st, input bit cmd);
    logic [6:0] sa; logic [7:0] vr, cr, rg, d; logic [31:0] v;
    sa = (mst || s_cfg[0]) ? s_sa : mst_slave;
    vr = (mst || s_cfg[1]) ? s_vr : mst_vreg;
    cr = (mst || s_cfg[2]) ? s_cr : mst_creg;
    rg = (cmd && !s_cfg[3]) ? cr : vr;
    v  = (mst || s_cfg[4]) ? s_val : mst_cmdval;
    case (st)
      2'd0: d = v[31:24];
      2'd1: d = v[23:16];
      2'd2: d = v[15:8];
      default: d = v[7:0];
    endcase
    return {sa, rg, d};
  endfunction

  task automatic wr(input logic [1:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 0;
    case (idx)
      2'd0: s_cfg = data[4:0];
      2'd1: begin s_sa = data[6:0]; s_vr = data[15:8]; s_cr = data[23:16]; end
      2'd2: s_val = data;
      default: ;
    endcase
  endtask

  task automatic run_req(input int u, input logic [1:0] st, input bit cmd,
                         input int stall, input bit poke, input string rq);
    logic [22:0] exp;
    @(negedge clk);
    req_state = st; req_cmd = cmd;
    exp = model(u == 1, st, cmd);
    rv[u] = 1;
    @(negedge clk);
    rv[u] = 0;
    chk(fv[u] === 1'b1, {rq, " R2 valid"}, 32'(fv[u]), 1);
    chk(rr[u] === 1'b0, "R2 ready low", 32'(rr[u]), 0);
    for (int i = 0; i < stall; i++) begin
      if (poke && i == 0) begin
        wr(2'd0, 32'($urandom)); wr(2'd1, $urandom); wr(2'd2, $urandom);
      end else @(negedge clk);
      chk(fv[u] === 1'b1 && {fs[u], fg[u], fd[u]} === exp,
          poke ? "R10 hold under writes" : "R3 hold", 32'({fs[u], fg[u], fd[u]}), 32'(exp));
    end
    chk({fs[u], fg[u], fd[u]} === exp, rq, 32'({fs[u], fg[u], fd[u]}), 32'(exp));
    fr[u] = 1;
    @(negedge clk);
    fr[u] = 0;
    chk(fv[u] === 1'b0, "R3 drop", 32'(fv[u]), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rv[0] = 0; rv[1] = 0; fr[0] = 0; fr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(fv[u] === 0, "R1 valid", 32'(fv[u]), 0);
      chk(re[u] === 0, "R1 err", 32'(re[u]), 0);
      chk(rr[u] === 1, "R1 ready", 32'(rr[u]), 1);
    end
    mst_slave = 7'h2a; mst_vreg = 8'h11; mst_creg = 8'h22; mst_cmdval = 32'hA1B2C3D4;
    run_req(0, 2'd0, 1'b0, 0, 0, "R1 unconfigured uses master");
    run_req(0, 2'd3, 1'b1, 1, 0, "R1 unconfigured command reg");

    wr(2'd1, 32'h00_5566_12 | 32'h0);
    wr(2'd2, 32'h01020304);
    wr(2'd0, 32'h1f);
    run_req(0, 2'd1, 1'b1, 0, 0, "R6 alias to voltage reg");
    wr(2'd0, 32'h17);
    run_req(0, 2'd1, 1'b1, 0, 0, "R6 own command reg");
    run_req(0, 2'd2, 1'b0, 0, 0, "R7 retention byte");
    run_req(0, 2'd3, 1'b0, 0, 0, "R7 off byte");
    wr(2'd3, 32'hffffffff);
    run_req(0, 2'd0, 1'b0, 0, 0, "R4 index 3 ignored");
    wr(2'd0, 32'hffffffe0);
    run_req(0, 2'd0, 1'b1, 0, 0, "R4 upper cfg bits ignored");
    run_req(1, 2'd2, 1'b1, 0, 0, "R9 master ignores enables");

    @(negedge clk);
    req_state = 2'd3; rv[1] = 1;
    @(negedge clk);
    rv[1] = 0;
    chk(re[1] === 1, "R8 err pulse", 32'(re[1]), 1);
    chk(fv[1] === 0, "R8 no frame", 32'(fv[1]), 0);
    chk(rr[1] === 1, "R8 ready kept", 32'(rr[1]), 1);
    @(negedge clk);
    chk(re[1] === 0, "R8 pulse single", 32'(re[1]), 0);

    run_req(0, 2'd1, 1'b0, 3, 1, "R10 pending writes");
    run_req(0, 2'd1, 1'b0, 0, 0, "R10 writes applied next");

    for (int n = 0; n < 80; n++) begin
      int u; logic [1:0] st;
      u = $urandom_range(0, 1);
      st = 2'($urandom);
      if (u == 1 && st == 2'd3) st = 2'd0;
      if ($urandom_range(0, 2) == 0) wr(2'($urandom_range(0, 2)), $urandom);
      mst_slave = 7'($urandom); mst_vreg = 8'($urandom);
      mst_creg = 8'($urandom); mst_cmdval = $urandom;
      run_req(u, st, 1'($urandom), $urandom_range(0, 3), $urandom_range(0, 5) == 0,
              u == 1 ? "R9 random master" : "R5 random frame");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule